// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Through Word Cache

This block is a small cache placed between a processor's load/store or fetch stage and a slower word-addressed main memory. Each line holds a single data word, so the word address splits into a set index (the low bits) and a tag (every remaining bit). Each set has two ways and a one-bit pointer that names the way to replace next.

Reads that hit return after a fixed, parameterised hit latency. Reads that miss send one word read to memory, write the returned word into the victim way, and then answer the requester. Every store updates or allocates a line in the cache. The store is also sent to memory in the cycle it is accepted, and it completes only after memory acknowledges it. Only one request is in flight at a time. The requester-side ready signal is low from acceptance until the response cycle is over.

Top module: `wt2_cache`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid and mem_req_valid are 0, and no address hits, so the first read of any address is a miss.
- R2: The set count is CAP_BYTES/8. The set index is the low log2(CAP_BYTES/8) bits of req_addr, and the tag is all the upper bits. Two addresses with the same index but different tags can be held at once, one in each way.
- R3: A read hit raises rsp_valid for one cycle, HIT_LAT cycles after the acceptance cycle, with the stored word on rsp_rdata. It issues no memory request.
- R4: A read miss drives mem_req_valid with mem_req_we=0 and mem_req_addr=req_addr in the acceptance cycle. The returned word is written into the cache. It is answered on rsp_rdata in the cycle after mem_rsp_valid, so with a memory delay of L cycles the response comes L+1 cycles after acceptance.
- R5: A read hit in way 0 sets the set's replacement pointer to 1. A read hit in way 1 sets it to 0.
- R6: The replacement pointer of each set is 0 after reset. A refill, or a store that misses, writes the way the pointer names and then inverts the pointer. A valid line in the other way is not disturbed.
- R7: A store that hits overwrites that way's word and sets the pointer to the other way. A store that misses allocates by the rule in R6. Later read hits return the stored word.
- R8: Every store drives mem_req_valid with mem_req_we=1 and the request's address and data in its acceptance cycle. Its rsp_valid comes in the cycle after mem_rsp_valid, which is L+1 cycles after acceptance.
- R9: Only one request is outstanding. req_ready is 0 from the cycle after acceptance through the response cycle, and it is 1 again in the cycle after rsp_valid.
- R10: Both ways of a set never hold the same valid tag. If they did, way 0 would be chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Cache idle and able to accept |
| req_addr | input | AW | Word address |
| req_we | input | 1 | 1 = store, 0 = load |
| req_wdata | input | DW | Store data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Load result |
| mem_req_valid | output | 1 | Memory access issued this cycle |
| mem_req_we | output | 1 | 1 = memory write |
| mem_req_addr | output | AW | Memory word address |
| mem_req_wdata | output | DW | Memory write data |
| mem_rsp_valid | input | 1 | Memory read data or write acknowledge |
| mem_rsp_rdata | input | DW | Memory read data |

## Verification
The assertions assume that memory returns exactly one mem_rsp_valid pulse for each mem_req_valid. They also assume that no pulse arrives while the cache is idle or serving a hit. The stimulus meets this by driving the memory side from a fixed-delay model that answers only the requests it sampled. The requester holds req_valid only in the cycle it offers a request, and only while req_ready is high. Request inputs are kept at defined values from reset onward, so the same-tag check in R10 never sees undefined tags.

// File: rtl/wt2_cache.sv
module wt2_cache #(
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int CAP_BYTES = 64,
  parameter int HIT_LAT   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_we,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_req_valid,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_rdata
);
  localparam int SETS = CAP_BYTES / 8;
  localparam int IW   = $clog2(SETS);
  localparam int TW   = AW - IW;
  localparam int CW   = $clog2(HIT_LAT + 1);

  typedef enum logic [2:0] {S_IDLE, S_HIT, S_MISS, S_STORE, S_RESP} st_t;
  st_t state;

  logic [TW-1:0] tag0 [SETS];
  logic [TW-1:0] tag1 [SETS];
  logic [DW-1:0] dat0 [SETS];
  logic [DW-1:0] dat1 [SETS];
  logic [SETS-1:0] v0, v1, lru;

  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  wire [IW-1:0] idx  = req_addr[IW-1:0];
  wire [TW-1:0] rtag = req_addr[AW-1:IW];
  wire m0   = v0[idx] && (tag0[idx] == rtag);
  wire m1   = v1[idx] && (tag1[idx] == rtag);
  wire hit  = m0 || m1;
  wire hway = !m0;
  wire acc  = req_valid && req_ready;

  wire [IW-1:0] fidx = addr_q[IW-1:0];
  wire fill = (state == S_MISS) && mem_rsp_valid;
  wire st   = acc && req_we;

  logic          wr_en, wr_way;
  logic [IW-1:0] wr_idx;
  logic [TW-1:0] wr_tag;
  logic [DW-1:0] wr_data;

  always_comb begin
    wr_en   = st || fill;
    wr_idx  = fill ? fidx : idx;
    wr_way  = fill ? lru[fidx] : (hit ? hway : lru[idx]);
    wr_tag  = fill ? addr_q[AW-1:IW] : rtag;
    wr_data = fill ? mem_rsp_rdata : req_wdata;
  end

  wire          rd_hit  = acc && !req_we && hit;
  wire [IW-1:0] lru_idx = wr_en ? wr_idx : idx;
  wire          lru_new = wr_en ? !wr_way : !hway;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v0  <= '0;
      v1  <= '0;
      lru <= '0;
    end else begin
      if (wr_en && !wr_way) v0[wr_idx] <= 1'b1;
      if (wr_en &&  wr_way) v1[wr_idx] <= 1'b1;
      if (wr_en || rd_hit)  lru[lru_idx] <= lru_new;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !wr_way) begin
      tag0[wr_idx] <= wr_tag;
      dat0[wr_idx] <= wr_data;
    end
    if (wr_en && wr_way) begin
      tag1[wr_idx] <= wr_tag;
      dat1[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (acc) begin
          if (req_we) begin
            data_q <= req_wdata;
            state  <= S_STORE;
          end else if (hit) begin
            data_q <= m0 ? dat0[idx] : dat1[idx];
            cnt    <= CW'(HIT_LAT - 1);
            state  <= S_HIT;
          end else begin
            addr_q <= req_addr;
            state  <= S_MISS;
          end
        end
        S_HIT:   if (cnt == '0) state <= S_IDLE; else cnt <= cnt - 1'b1;
        S_MISS:  if (mem_rsp_valid) begin
          data_q <= mem_rsp_rdata;
          state  <= S_RESP;
        end
        S_STORE: if (mem_rsp_valid) state <= S_RESP;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == S_IDLE);
  assign rsp_valid     = (state == S_RESP) || (state == S_HIT && cnt == '0);
  assign rsp_rdata     = data_q;
  assign mem_req_valid = acc && (req_we || !hit);
  assign mem_req_we    = req_we;
  assign mem_req_addr  = req_addr;
  assign mem_req_wdata = req_wdata;

  a_r10_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !(m0 && m1));
  a_r5_hit_way0: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_we && m0) |=> lru[$past(idx)]);
  a_r5_hit_way1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_we && !m0 && m1) |=> !lru[$past(idx)]);
  a_r9_miss_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_we && !hit) |=> (!req_ready && !rsp_valid));
  a_r9_ready_back: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready);
  a_r4_fill_answer: assert property (@(posedge clk) disable iff (!rst_n)
    fill |=> (rsp_valid && rsp_rdata == $past(mem_rsp_rdata)));
endmodule

// File: tb/wt2_cache_tb.sv
module wt2_cache_tb;
  localparam int CLK_P   = 10;
  localparam int AW      = 16;
  localparam int DW      = 32;
  localparam int HIT_LAT = 2;
  localparam int MEM_LAT = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_req_valid, mem_req_we;
  logic [DW-1:0] rsp_rdata, mem_req_wdata;
  logic [AW-1:0] mem_req_addr;
  logic mem_rsp_valid = 0;
  logic [DW-1:0] mem_rsp_rdata = '0;

  always #(CLK_P/2) clk = ~clk;

  wt2_cache #(.AW(AW), .DW(DW), .CAP_BYTES(64), .HIT_LAT(HIT_LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata));

  int checks = 0, fails = 0, cyc = 0, rd_cnt = 0, sent = 0, got = 0, acc_cyc = 0;
  logic [DW-1:0] tb_mem [256];

  typedef struct { logic [DW-1:0] d; int lat; bit chk_d; string r; } exp_t;
  exp_t q[$];

  function automatic logic [DW-1:0] fv(int a);
    return 32'h5A00_0000 ^ (a * 32'h0001_0101);
  endfunction

  task automatic chk(input bit ok, input string r, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    for (int i = 0; i < 256; i++) tb_mem[i] = fv(i);
    forever begin
      @(posedge clk);
      mem_rsp_valid <= 1'b0;
      if (rst_n && mem_req_valid) begin
        automatic int a = int'(mem_req_addr[7:0]);
        automatic logic [DW-1:0] v = tb_mem[a];
        if (mem_req_we) tb_mem[a] = mem_req_wdata;
        else rd_cnt++;
        repeat (MEM_LAT - 1) @(posedge clk);
        mem_rsp_rdata <= v;
        mem_rsp_valid <= 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q.size() == 0) chk(0, "R9 unexpected response", 32'd1, 32'd0);
      else begin
        automatic exp_t e = q.pop_front();
        chk(cyc - acc_cyc == e.lat, {e.r, " latency"}, DW'(cyc - acc_cyc), DW'(e.lat));
        if (e.chk_d) chk(rsp_rdata == e.d, {e.r, " data"}, rsp_rdata, e.d);
        chk(!req_ready, "R9 ready low in response cycle", DW'(req_ready), 32'd0);
      end
      got++;
    end
  end

  task automatic do_req(input int a, input bit we, input logic [DW-1:0] wd,
                        input logic [DW-1:0] exp_d, input bit miss, input string r);
    automatic int rd0 = rd_cnt;
    automatic exp_t e;
    @(negedge clk);
    req_valid = 1; req_addr = AW'(a); req_we = we; req_wdata = wd;
    acc_cyc = cyc;
    e.d = exp_d; e.lat = (we || miss) ? MEM_LAT + 1 : HIT_LAT; e.chk_d = !we; e.r = r;
    q.push_back(e);
    sent++;
    #1;
    chk(mem_req_valid == (we || miss), {r, " R4 R8 memory request in acceptance cycle"},
        DW'(mem_req_valid), DW'(we || miss));
    if (we || miss)
      chk(mem_req_we == we && mem_req_addr == AW'(a), {r, " R4 R8 memory request fields"},
          DW'(mem_req_addr), DW'(a));
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R9 ready low after accept", DW'(req_ready), 32'd0);
    wait (got == sent);
    @(negedge clk);
    chk(req_ready, "R9 ready back after response", DW'(req_ready), 32'd1);
    chk(rd_cnt - rd0 == int'(!we && miss), {r, " R3 R4 memory read count"},
        DW'(rd_cnt - rd0), DW'(!we && miss));
    if (we) chk(tb_mem[a] == wd, {r, " R8 write-through data"}, tb_mem[a], wd);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog expired", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  localparam int A = 3, B = 11, C = 19, D = 27;
  localparam logic [DW-1:0] X1 = 32'hC0FF_EE01, X2 = 32'hBEEF_0002;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1 reset outputs",
        {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'd4);
    do_req(A, 0, 0, fv(A), 1, "R1 R6 first read misses, fills way0");
    do_req(B, 0, 0, fv(B), 1, "R6 second fill to way1");
    do_req(A, 0, 0, fv(A), 0, "R3 R5 hit way0");
    do_req(B, 0, 0, fv(B), 0, "R3 R5 hit way1");
    do_req(C, 0, 0, fv(C), 1, "R5 R6 fill evicts way0");
    do_req(B, 0, 0, fv(B), 0, "R6 other way kept");
    do_req(A, 0, 0, fv(A), 1, "R6 A evicted earlier");
    do_req(B, 1, X1, 0, 0, "R7 R8 store hit");
    do_req(B, 0, 0, X1, 0, "R7 read after store hit");
    do_req(D, 1, X2, 0, 1, "R7 R8 store miss allocates");
    do_req(D, 0, 0, X2, 0, "R7 allocated line hits");
    do_req(B, 0, 0, X1, 0, "R7 store hit kept line");
    do_req(A, 0, 0, fv(A), 1, "R7 allocate evicted way0");
    do_req(C, 0, 0, fv(C), 1, "R6 fill to way1");
    do_req(B, 0, 0, X1, 1, "R8 refill returns written-through word");
    do_req(6, 0, 0, fv(6), 1, "R2 low tag");
    do_req(134, 0, 0, fv(134), 1, "R2 high tag same set");
    do_req(6, 0, 0, fv(6), 0, "R2 R10 both tags coexist way0");
    do_req(134, 0, 0, fv(134), 0, "R2 R10 both tags coexist way1");
    do_req(5, 0, 0, fv(5), 1, "R2 other set independent");
    do_req(5, 0, 0, fv(5), 0, "R3 other set hit");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule